// File: doc/BRIEF.md
# Tick-Driven Event Timer with Timestamp

This peripheral gives software a programmable delay and a time base behind one small register window. A down-counter is loaded with a tick count. While it is enabled, each tick-enable pulse lowers it by one. When it runs out, a sticky expiry flag is raised, and that flag drives a level interrupt. The counter then either stops (one-shot) or reloads the last written value and keeps running (periodic with reload). A second counter, the timestamp, rises by one on every tick pulse, does not depend on the event counter, and wraps at its width.

The control byte holds the run enable, the periodic select, the reload select and the expiry flag. The expiry flag is cleared by writing a one to it. Because of this, one control write can halt the counter and acknowledge the interrupt together. A typical arming sequence is: write 0x80 to the control byte (halt, acknowledge), write the count, then write 0x81 (acknowledge, run). Read data is registered and appears on the cycle after the address is presented.

Top module: `evtick_timer`

## Requirements
- R1: After reset the counter, its load value, the control byte, the timestamp and `irq` are all zero.
- R2: The control register is the word at byte offset 0x14, lane 0. It is written only when `bus_be[0]` is set. Bits 0 (run), 1 (periodic) and 2 (reload) take the written value. It reads back as {expiry at bit 7, reload, periodic, run}, and bits 3 to 6 always read zero.
- R3: Writing 1 to control bit 7 clears the expiry flag. Writing 0 there leaves the flag unchanged.
- R4: A count N (N >= 1) with run set raises the expiry flag on exactly the N-th tick pulse. Unless both periodic and reload are set, run is then cleared and the counter reads 0. A count of 0 expires on the first tick pulse.
- R5: The counter does not change on cycles without a tick pulse, or while run is clear.
- R6: With run, periodic and reload all set, each expiry reloads the last written count and run stays set. The flag is therefore raised again every N ticks.
- R7: Periodic without reload, and reload without periodic, behave as one-shot.
- R8: A write to offset 0x00 merges the strobed bytes of `bus_wdata` into the stored load value, and bits above the counter width are dropped. The counter restarts from the merged value, even while running. A read of 0x00 returns the current count.
- R9: The timestamp at offset 0x08 rises by one on every tick pulse whatever the value of run, wraps to zero, and ignores writes.
- R10: `irq` is high exactly while the expiry flag is set. A single 0x80 control write stops counting and drops `irq`.
- R11: If an expiry and a flag-clearing control write fall on the same cycle, the flag stays set. Run takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| tick_en | input | 1 | Time-base pulse that advances both counters |
| irq | output | 1 | Level interrupt, high while the expiry flag is set |

## Verification
The in-module properties check every cycle that:
- an expiry always sets the flag, and the flag survives any write that does not clear it;
- the count holds without a tick;
- a load or a reload leaves the counter equal to the stored load value;
- the timestamp steps by exactly one per tick.

Only the bench scenarios can show the following:
- the exact tick count to expiry across a sweep of load values;
- the read-back encoding of the control byte;
- byte-lane merging;
- wrap of the timestamp;
- the same-cycle collision between an expiry and an acknowledge.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned LANES   = BUS_W / 8;
  // word indices (byte offset / 4); fixed by the register window layout
  localparam int unsigned CNT_WORD   = 0;
  localparam int unsigned STAMP_WORD = 2;
  localparam int unsigned CTRL_WORD  = 5;

  typedef struct packed {
    logic tc;
    logic rld;
    logic per;
    logic en;
  } ctrl_t;

  localparam int unsigned TC_BIT  = 7;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned PER_BIT = 1;
  localparam int unsigned RLD_BIT = 2;
endpackage

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
  import evtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  logic       expire,
  output ctrl_t      ctrl_q,
  output logic       irq
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d.en  = wbyte[EN_BIT];
      ctrl_d.per = wbyte[PER_BIT];
      ctrl_d.rld = wbyte[RLD_BIT];
      if (wbyte[TC_BIT]) ctrl_d.tc = 1'b0;
    end else if (expire && !(ctrl_q.per && ctrl_q.rld)) begin
      ctrl_d.en = 1'b0;
    end
    if (expire) ctrl_d.tc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  assign irq = ctrl_q.tc;

  // R4
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> ctrl_q.tc);
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.tc && !(wr && wbyte[TC_BIT])) |=> ctrl_q.tc);
  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !wr && !(ctrl_q.per && ctrl_q.rld)) |=> !ctrl_q.en);
endmodule

// File: rtl/evtmr_downcnt.sv
module evtmr_downcnt
  import evtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BUS_W-1:0] wdata,
  input  logic [LANES-1:0] be,
  input  logic             run,
  input  logic             tick,
  input  logic             reload_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] load_q;
  logic [BUS_W-1:0] cur_w, merged;

  assign cur_w = BUS_W'(load_q);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : cur_w[8*b +: 8];
  end

  logic step;
  assign step   = run && tick && !load;
  assign expire = step && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      load_q <= merged[CNT_W-1:0];
      cnt_q  <= merged[CNT_W-1:0];
    end else if (expire) begin
      cnt_q <= reload_mode ? load_q : '0;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !(run && tick)) |=> $stable(cnt_q));
  // R8
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == load_q));
  // R6
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && reload_mode) |=> (cnt_q == load_q));
endmodule

// File: rtl/evtmr_stamp.sv
module evtmr_stamp #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [TS_W-1:0] ts_q
);
  always_ff @(posedge clk) begin
    if (rst)       ts_q <= '0;
    else if (tick) ts_q <= ts_q + TS_W'(1);
  end

  // R9
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (ts_q == TS_W'($past(ts_q) + TS_W'(1))));
  // R9
  stamp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ts_q));
endmodule

// File: rtl/evtick_timer.sv
module evtick_timer
  import evtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  output logic              irq
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              cnt_wr, ctrl_wr, expire;
  logic [CNT_W-1:0]  cnt;
  logic [TS_W-1:0]   ts;
  ctrl_t             ctrl;

  assign word    = bus_addr[ADDR_W-1:2];
  assign cnt_wr  = bus_wr && (word == WORD_W'(CNT_WORD)) && (|bus_be);
  assign ctrl_wr = bus_wr && (word == WORD_W'(CTRL_WORD)) && bus_be[0];

  evtmr_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_wr), .wdata(bus_wdata), .be(bus_be),
    .run(ctrl.en), .tick(tick_en), .reload_mode(ctrl.per && ctrl.rld),
    .cnt_q(cnt), .expire(expire)
  );

  evtmr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wbyte(bus_wdata[7:0]),
    .expire(expire), .ctrl_q(ctrl), .irq(irq)
  );

  evtmr_stamp #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst(rst), .tick(tick_en), .ts_q(ts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (word)
        WORD_W'(CNT_WORD):   bus_rdata <= 32'(cnt);
        WORD_W'(STAMP_WORD): bus_rdata <= 32'(ts);
        WORD_W'(CTRL_WORD):  bus_rdata <= {24'd0, ctrl.tc, 4'd0, ctrl.rld, ctrl.per, ctrl.en};
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/tb_evtick_timer.sv
module tb_evtick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        irq;

  int checks = 0, fails = 0, ticks_total = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evtick_timer #(.ADDR_W(5), .CNT_W(16), .TS_W(8)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be = 4'hF, bit tk = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1; tick_en = tk;
    if (tk) ticks_total++;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1; ticks_total++;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic arm(logic [31:0] n, logic [7:0] c);
    wr(5'h14, 32'h80);
    wr(5'h00, n);
    wr(5'h14, {24'd0, c});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h00, d); check("R1 count", d, 0);
    rd(5'h08, d); check("R1 stamp", d, 0);
    rd(5'h14, d); check("R1 ctrl", d, 0);
    check("R1 irq", irq, 0);

    // R2 control encoding and lane strobe
    wr(5'h14, 32'h06); rd(5'h14, d); check("R2 write 0x06", d, 32'h06);
    wr(5'h14, 32'h7E); rd(5'h14, d); check("R2 bits3-6 zero", d, 32'h06);
    wr(5'h14, 32'h01, 4'b1110); rd(5'h14, d); check("R2 lane0 off", d, 32'h06);
    wr(5'h14, 32'h00); rd(5'h14, d); check("R2 clear", d, 0);

    // R4 sweep of load values
    for (int n = 0; n <= 24; n++) begin
      arm(n, 8'h81);
      cnt = 0;
      while (!irq && cnt < 100) begin tick(1); cnt++; end
      check("R4 ticks to expiry", cnt, (n == 0) ? 1 : n);
      rd(5'h14, d); check("R4 run cleared", d, 32'h80);
      rd(5'h00, d); check("R4 count zero", d, 0);
      check("R10 irq with flag", irq, 1);
    end

    // R3 write-one-to-clear
    wr(5'h14, 32'h00); rd(5'h14, d); check("R3 zero keeps flag", d, 32'h80);
    check("R3 irq kept", irq, 1);
    wr(5'h14, 32'h80); rd(5'h14, d); check("R3 one clears", d, 0);
    check("R3 irq dropped", irq, 0);

    // R5 no change without tick or while stopped
    arm(5, 8'h81);
    repeat (10) @(negedge clk);
    rd(5'h00, d); check("R5 idle hold", d, 5);
    wr(5'h14, 32'h00); tick(3);
    rd(5'h00, d); check("R5 stopped hold", d, 5);

    // R10 single 0x80 write halts and acknowledges
    arm(10, 8'h81); tick(3);
    rd(5'h00, d); check("R10 running", d, 7);
    wr(5'h14, 32'h80); tick(5);
    rd(5'h00, d); check("R10 halted count", d, 7);
    check("R10 irq low", irq, 0);

    // R6 periodic with reload
    arm(4, 8'h87);
    tick(3); check("R6 not yet", irq, 0);
    tick(1); check("R6 first expiry", irq, 1);
    rd(5'h14, d); check("R6 run kept", d, 32'h87);
    rd(5'h00, d); check("R6 reloaded", d, 4);
    wr(5'h14, 32'h87);
    tick(3); check("R6 second not yet", irq, 0);
    tick(1); check("R6 second expiry", irq, 1);

    // R7 periodic-only and reload-only act as one-shot
    arm(3, 8'h83); tick(3);
    rd(5'h14, d); check("R7 periodic only", d, 32'h82);
    rd(5'h00, d); check("R7 periodic only count", d, 0);
    arm(3, 8'h85); tick(3);
    rd(5'h14, d); check("R7 reload only", d, 32'h84);

    // R8 byte merge, width truncation, restart while running
    wr(5'h14, 32'h80);
    wr(5'h00, 32'h0000_0100);
    wr(5'h00, 32'hAAAA_AAFF, 4'b0001);
    rd(5'h00, d); check("R8 lane merge", d, 32'h01FF);
    wr(5'h00, 32'hFFFF_0005); rd(5'h00, d); check("R8 truncate", d, 5);
    wr(5'h00, 32'h0000_0200); wr(5'h14, 32'h81); tick(3);
    rd(5'h00, d); check("R8 running", d, 32'h01FD);
    wr(5'h00, 32'h10); rd(5'h00, d); check("R8 restart value", d, 32'h10);
    tick(2); rd(5'h00, d); check("R8 restart count", d, 32'h0E);

    // R11 expiry and flag clear on the same cycle
    arm(2, 8'h81); tick(1);
    wr(5'h14, 32'h81, 4'hF, 1);
    rd(5'h14, d); check("R11 flag survives", d, 32'h81);
    check("R11 irq", irq, 1);

    // R9 timestamp: counts all ticks, wraps, ignores writes
    wr(5'h14, 32'h80);
    rd(5'h08, d); check("R9 stamp tracks ticks", d, ticks_total % 256);
    wr(5'h08, 32'h55);
    rd(5'h08, d); check("R9 write ignored", d, ticks_total % 256);
    tick(256 - (ticks_total % 256) - 1);
    rd(5'h08, d); check("R9 at top", d, 255);
    tick(1);
    rd(5'h08, d); check("R9 wrap", d, 0);
    tick(7);
    rd(5'h08, d); check("R9 after wrap", d, 7);

    finish_run();
  end
endmodule